// File: doc/BRIEF.md
# Complementary Dead-Time Generator

This block turns one PWM drive signal into a pair of complementary gate signals for the two switches of a half bridge. A short guard interval, the dead time, is placed at each switching instant so that one switch turns off before the other turns on. Output A follows the source, but each of its turn-on edges is held back by a programmed number of clock ticks. Output B follows the inverse of the source, and each of its turn-on edges is held back as well. B's turn-on comes from the source's falling edge, and B is the falling-delayed source inverted.

Each of the two delay paths has its own count, its own enable and its own polarity bit. When a path is disabled, its edge passes with no added delay. Each delay counter restarts on every source edge. A source pulse that is not longer than the delay on its path produces no output pulse. With the default polarity, A not inverted and B inverted, the two outputs are never active together. The source is registered once on entry. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `db_deadband`

## Requirements
- R1: While reset is applied, the internal delay state is cleared. With `inv_a`=0 and `inv_b`=1, both `out_a` and `out_b` read 0.
- R2: With `rise_en`=1, `pwm_in` is first sampled high at clock edge e and stays high. The A path then turns on at edge e+1+`rise_dly`, so `out_a` goes to 1 with `inv_a`=0.
- R3: When `pwm_in` is first sampled low at edge e, the A path turns off at edge e+1, whatever its delay.
- R4: With `fall_en`=1, `pwm_in` is first sampled low at edge e and stays low. The B path then turns on at edge e+1+`fall_dly`, so `out_b` goes to 1 with `inv_b`=1. When `pwm_in` is first sampled high at edge e, the B path turns off at edge e+1.
- R5: A source level held for L samples gives an output pulse of L−N cycles on that path when L>N. When L≤N, no pulse appears. N is the path's delay.
- R6: With a path's enable at 0, that path follows the source with a latency of one cycle, and its delay count has no effect.
- R7: `inv_a`=1 inverts `out_a`, and `inv_b`=0 removes the inversion from `out_b`. Each bit acts on its own output only.
- R8: With `inv_a`=0 and `inv_b`=1, `out_a` and `out_b` are never both 1, for any source waveform, delay or enable setting.
- R9: A source edge that arrives while a delay is counting restarts that path's count from zero. The delay is measured from the latest edge.
- R10: The rising and falling delay counts are independent, and each affects only its own path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one delay tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Source PWM signal |
| rise_en | input | 1 | Enables the turn-on delay of the A path |
| fall_en | input | 1 | Enables the turn-on delay of the B path |
| rise_dly | input | CW | Delay of the A path, in ticks |
| fall_dly | input | CW | Delay of the B path, in ticks |
| inv_a | input | 1 | 1 inverts out_a |
| inv_b | input | 1 | 1 inverts the B path (default complementary setting) |
| out_a | output | 1 | High-side gate signal |
| out_b | output | 1 | Low-side gate signal |

## Verification
A counter that is stuck, misloaded or not cleared on a source edge shows up on the next turn-on edge of its output. That edge arrives early or late by the size of the error, within one PWM run of the fault. A path whose output register holds a stale level produces an overlap of `out_a` and `out_b` in that same cycle. A lost inversion flips an output from the first compared cycle after reset. The bench compares both outputs on every cycle against a model built on run lengths, so any such deviation is reported within one cycle of appearing at the ports.

// File: rtl/db_pkg.sv
package db_pkg;
  // which transition of the source a delay path holds back
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

  localparam int DB_CW_DEFAULT = 10;
endpackage

// File: rtl/db_reset_sync.sv
module db_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/db_edge_delay.sv
module db_edge_delay
  import db_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_RISE,
  parameter int         CW   = DB_CW_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src,
  input  logic          en,
  input  logic [CW-1:0] dly,
  output logic          dout
);
  logic          x;        // source oriented so the delayed edge is a rise
  logic [CW-1:0] cnt_q, cnt_d;
  logic          y_q, y_d;
  logic          cnt_ce;

  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign x    = ~src;
      assign dout = ~y_q;
    end else begin : g_rise
      assign x    = src;
      assign dout = y_q;
    end
  endgenerate

  // next state: count while active, saturate at the programmed delay
  always_comb begin
    cnt_d = cnt_q;
    y_d   = y_q;
    if (!en) begin
      cnt_d = '0;
      y_d   = x;
    end else if (!x) begin
      cnt_d = '0;
      y_d   = 1'b0;
    end else begin
      if (cnt_q < dly) cnt_d = cnt_q + 1'b1;
      y_d = (cnt_q >= dly);
    end
  end

  assign cnt_ce = !en || !x || (cnt_q < dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      y_q   <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      y_q <= y_d;
    end
  end

  // R3 / R4: the undelayed edge is never held back
  a_r3_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    !x |=> !y_q);

  // R5: an asserted output always needs the oriented source high before it
  a_r5_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    (y_q && !$past(y_q)) |-> $past(x));

  // R6: a disabled path is a one-cycle pass-through
  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (y_q == $past(x)));

  // R9: an opposing edge clears the count
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !x |=> (cnt_q == '0));
endmodule

// File: rtl/db_deadband.sv
module db_deadband
  import db_pkg::*;
#(
  parameter int CW = DB_CW_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_in,
  input  logic          rise_en,
  input  logic          fall_en,
  input  logic [CW-1:0] rise_dly,
  input  logic [CW-1:0] fall_dly,
  input  logic          inv_a,
  input  logic          inv_b,
  output logic          out_a,
  output logic          out_b
);
  localparam int NPATH = 2;

  logic             rst_n_int;
  logic             src_q;
  logic [NPATH-1:0] path_en;
  logic [CW-1:0]    path_dly [NPATH];
  logic [NPATH-1:0] path_out;
  logic [NPATH-1:0] path_inv;

  db_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) src_q <= 1'b0;
    else            src_q <= pwm_in;
  end

  assign path_en     = {fall_en, rise_en};
  assign path_dly[0] = rise_dly;
  assign path_dly[1] = fall_dly;
  assign path_inv    = {inv_b, inv_a};

  // path 0 holds back turn-on of A, path 1 holds back the source's falling edge
  for (genvar p = 0; p < NPATH; p++) begin : g_path
    localparam edge_kind_e K = (p == 0) ? EDGE_RISE : EDGE_FALL;
    db_edge_delay #(.KIND(K), .CW(CW)) u_dly (
      .clk   (clk),
      .rst_n (rst_n_int),
      .src   (src_q),
      .en    (path_en[p]),
      .dly   (path_dly[p]),
      .dout  (path_out[p])
    );
  end

  assign out_a = path_out[0] ^ path_inv[0];
  assign out_b = path_out[1] ^ path_inv[1];

  // R8: complementary setting never drives both switches
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!inv_a && inv_b) |-> !(out_a && out_b));

  // R1: reset leaves both gates off under the complementary setting
  a_r1_reset_off: assert property (@(posedge clk)
    (!rst_n_int && !inv_a && inv_b) |-> (!out_a && !out_b));
endmodule

// File: tb/tb_db_deadband.sv
module tb_db_deadband;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pwm_in;
  logic          rise_en, fall_en;
  logic [CW-1:0] rise_dly, fall_dly;
  logic          inv_a, inv_b;
  logic          out_a, out_b;

  int n_vec  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  db_deadband #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .rise_en(rise_en), .fall_en(fall_en),
    .rise_dly(rise_dly), .fall_dly(fall_dly),
    .inv_a(inv_a), .inv_b(inv_b),
    .out_a(out_a), .out_b(out_b)
  );

  // expected path level from the run length of the relevant source level
  function automatic bit path_on(int run, bit en, int dly);
    int thr;
    thr = en ? dly + 1 : 1;
    return run >= thr;
  endfunction

  task automatic check(string tag, bit act, bit exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic run_seg(string tag, bit re, bit fe, int rd, int fd,
                         bit ia, bit ib, int minl, int maxl, int nvec);
    int  hi_run, lo_run, remain;
    bit  lvl, have_exp, ea, eb;
    rst_n    = 1'b0;
    pwm_in   = 1'b0;
    rise_en  = re;  fall_en  = fe;
    rise_dly = CW'(rd); fall_dly = CW'(fd);
    inv_a    = ia;  inv_b    = ib;
    repeat (3) @(negedge clk);
    // R1: outputs while in reset
    check({"R1 reset A ", tag}, out_a, ia);
    check({"R1 reset B ", tag}, out_b, ~ib);
    rst_n = 1'b1;
    @(negedge clk);
    hi_run = 0; lo_run = 1; have_exp = 1'b0;
    lvl = 1'b0; remain = $urandom_range(maxl, minl);
    for (int i = 0; i < nvec; i++) begin
      @(negedge clk);
      if (have_exp) begin
        check({"A ", tag}, out_a, ea);
        check({"B ", tag}, out_b, eb);
        if (!ia && ib) check("R8 overlap", out_a & out_b, 1'b0);
      end
      if (remain == 0) begin
        lvl = ~lvl;
        remain = $urandom_range(maxl, minl);
      end
      remain--;
      ea = path_on(hi_run, re, rd) ^ ia;
      eb = ~path_on(lo_run, fe, fd) ^ ib;
      have_exp = 1'b1;
      if (lvl) begin hi_run = (hi_run < 100000) ? hi_run + 1 : hi_run; lo_run = 0; end
      else     begin lo_run = (lo_run < 100000) ? lo_run + 1 : lo_run; hi_run = 0; end
      pwm_in = lvl;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R2 R3 R4 R10: long runs, unequal delays
    run_seg("R2 R3 R4 R10", 1, 1, 5, 3, 0, 1, 8, 30, 300);
    run_seg("R10 swapped",  1, 1, 2, 11, 0, 1, 14, 40, 300);
    // R5: pulses around the delay length are removed or shortened
    run_seg("R5 short pulses", 1, 1, 8, 6, 0, 1, 1, 12, 400);
    // R9: edges arriving mid-count restart the count
    run_seg("R9 glitches", 1, 1, 6, 6, 0, 1, 1, 4, 300);
    // R6: disabled paths ignore their delay
    run_seg("R6 rise off", 0, 1, 9, 4, 0, 1, 2, 20, 250);
    run_seg("R6 fall off", 1, 0, 4, 9, 0, 1, 2, 20, 250);
    // R7: polarity bits
    run_seg("R7 inverted", 1, 1, 3, 5, 1, 0, 2, 20, 250);
    // corner: zero delay enabled
    run_seg("R2 R4 zero delay", 1, 1, 0, 0, 0, 1, 1, 6, 200);
    // random configurations
    for (int k = 0; k < 8; k++) begin
      run_seg("R8 random", 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
              $urandom_range(12, 0), $urandom_range(12, 0),
              (k < 5) ? 1'b0 : 1'($urandom_range(1, 0)),
              (k < 5) ? 1'b1 : 1'($urandom_range(1, 0)),
              1, 20, 300);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule